// File: doc/BRIEF.md
# SRAM power-up bias age checker

This block judges whether a chip has seen field use by looking at the contents its SRAM wakes up with. A fresh array settles with very nearly as many ones as zeros, and stress from stored data pushes that balance to one side over time. The block receives the power-up image as a stream of words. Each frame is marked by a start flag and an end flag. The block counts the one bits over the whole frame and compares that count with half the array size.

It has two kinds of run, and a start pulse together with a mode input selects one. A calibration run collects a fixed number of good frames. From the spread of their ones counts it learns a tolerance half-width equal to three standard deviations, expressed in bits. An authentication run takes a single good frame and reports the chip as used when the count lies outside half the array plus or minus that half-width, and as new otherwise. The learned half-width stays stored between runs. Frames of the wrong length are discarded and flagged, and the run carries on waiting for a good frame.

Top module: `pubias_age_checker`

## Requirements
- R1: The ones count of a frame is the number of set bits over every accepted word from the start-flagged word through the end-flagged word. It is reported on res_count with the result.
- R2: An authentication result has res_used = 0 when FRAME_BITS/2 - delta <= count <= FRAME_BITS/2 + delta, both bounds inclusive. It has res_used = 1 for a count below the band and for a count above it.
- R3: A calibration run ends after CAL_RUNS good frames. The stored half-width becomes the smallest integer d with (d*CAL_RUNS)^2 >= 9*(CAL_RUNS*sum(c^2) - (sum c)^2), where c is each frame's ones count.
- R4: The half-width reads 0 after reset. It changes only at the end of a calibration run and holds its value across authentication runs.
- R5: A frame whose end flag arrives with a total bit count other than FRAME_BITS is dropped. frame_err pulses for one cycle, the frame adds nothing to the calibration sums, and the run keeps accepting frames.
- R6: in_ready is high only while a run is in progress. busy rises in the cycle after an accepted start and falls only when a result is given.
- R7: res_valid is a one-cycle pulse given in the cycle busy is low again. A calibration result carries res_used = 0 and the last good count.
- R8: A start pulse that arrives during a run is ignored. The running run finishes in its own mode.
- R9: A synchronous active-high reset leaves busy, in_ready, res_valid and frame_err low and the half-width at 0.
- R10: A word that carries the start flag throws away any partial frame, and counting starts afresh from that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when idle |
| mode_cal | input | 1 | 1 selects calibration, 0 selects authentication, sampled with start |
| in_valid | input | 1 | Word on in_data is valid |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_data | input | WORD_W | Power-up image word |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| busy | output | 1 | Run in progress |
| frame_err | output | 1 | One-cycle pulse for a frame of wrong length |
| res_valid | output | 1 | One-cycle result pulse |
| res_used | output | 1 | Verdict, 1 means used |
| res_count | output | C_W | Ones count of the last good frame |
| res_delta | output | C_W | Stored tolerance half-width in bits |

## Verification
The bench places counts exactly on both edges of the learned band and one bit beyond each edge, and it also tries the all-zero and all-one images. A design with off-by-one or one-sided bounds would misjudge these counts. Malformed frames that are too short and too long are sent in the middle of a calibration run. If such a frame were accumulated, the learned half-width would change, and a constant-count calibration would no longer give zero. A stray start pulse is sent during a run, and a truncated frame is followed by a new start flag. A design that honoured the stray start would switch mode mid-run, and one that kept the partial frame would report an inflated count.

// File: rtl/pubias_pkg.sv
package pubias_pkg;

    // Control states of the top-level sequencer
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_WAIT
    } ctl_state_e;

    // States of the half-width search
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PREP,
        SQ_RUN
    } sq_state_e;

    // Squared multiple of sigma that defines the band (3 sigma -> 9)
    localparam int SIGMA_MULT_SQ = 9;

    // Width needed to count up to n inclusive
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pubias_frame_acc.sv
module pubias_frame_acc #(
    parameter int FRAME_BITS = 65536,
    parameter int WORD_W     = 32,
    parameter int C_W        = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              take,
    input  logic [WORD_W-1:0] data,
    input  logic              sof,
    input  logic              eof,
    output logic              done,
    output logic              ok,
    output logic [C_W-1:0]    ones
);
    localparam logic [C_W-1:0] FRAME_C = C_W'(FRAME_BITS);
    localparam logic [C_W-1:0] WORD_C  = C_W'(WORD_W);

    logic [C_W-1:0] run_ones, run_bits;
    logic [C_W-1:0] base_ones, base_bits;
    logic [C_W-1:0] nxt_ones, nxt_bits;
    logic [C_W-1:0] word_ones;

    always_comb begin
        word_ones = '0;
        for (int i = 0; i < WORD_W; i++) begin
            word_ones = word_ones + C_W'(data[i]);
        end
        base_ones = sof ? '0 : run_ones;
        base_bits = sof ? '0 : run_bits;
        // once past the frame size, the frame is bad anyway: hold
        if (base_bits > FRAME_C) begin
            nxt_ones = base_ones;
            nxt_bits = base_bits;
        end else begin
            nxt_ones = base_ones + word_ones;
            nxt_bits = base_bits + WORD_C;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_ones <= '0;
            run_bits <= '0;
            done     <= 1'b0;
            ok       <= 1'b0;
            ones     <= '0;
        end else begin
            done <= take && eof;
            if (take) begin
                if (eof) begin
                    run_ones <= '0;
                    run_bits <= '0;
                    ok       <= (nxt_bits == FRAME_C);
                    ones     <= nxt_ones;
                end else begin
                    run_ones <= nxt_ones;
                    run_bits <= nxt_bits;
                end
            end
        end
    end

endmodule

// File: rtl/pubias_cal_stats.sv
module pubias_cal_stats
    import pubias_pkg::*;
#(
    parameter int C_W      = 17,
    parameter int CAL_RUNS = 100
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           acc,
    input  logic [C_W-1:0] ones,
    output logic           last,
    output logic           done,
    output logic [C_W-1:0] delta
);
    localparam int N_W  = cnt_width(CAL_RUNS);
    localparam int S1_W = C_W + N_W;
    localparam int S2_W = 2 * C_W + N_W;
    localparam int V_W  = 2 * C_W + 2 * N_W + 4;

    sq_state_e       st;
    logic [N_W-1:0]  cnt;
    logic [S1_W-1:0] s1;
    logic [S2_W-1:0] s2;
    logic [V_W-1:0]  var9;
    logic [C_W-1:0]  cand;
    logic [V_W-1:0]  n_s2, s1_sq, spread9, scaled, scaled_sq;

    assign last = (cnt == N_W'(CAL_RUNS - 1));

    always_comb begin
        n_s2      = V_W'(s2) * V_W'(CAL_RUNS);
        s1_sq     = V_W'(s1) * V_W'(s1);
        spread9   = V_W'(SIGMA_MULT_SQ) * (n_s2 - s1_sq);
        scaled    = V_W'(cand) * V_W'(CAL_RUNS);
        scaled_sq = scaled * scaled;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_IDLE;
            cnt   <= '0;
            s1    <= '0;
            s2    <= '0;
            var9  <= '0;
            cand  <= '0;
            done  <= 1'b0;
            delta <= '0;
        end else begin
            done <= 1'b0;
            if (clr) begin
                st  <= SQ_IDLE;
                cnt <= '0;
                s1  <= '0;
                s2  <= '0;
            end else begin
                case (st)
                    SQ_IDLE: if (acc) begin
                        s1  <= s1 + S1_W'(ones);
                        s2  <= s2 + S2_W'(ones) * S2_W'(ones);
                        cnt <= last ? '0 : cnt + 1'b1;
                        if (last) st <= SQ_PREP;
                    end
                    SQ_PREP: begin
                        var9 <= spread9;
                        cand <= '0;
                        st   <= SQ_RUN;
                    end
                    SQ_RUN: begin
                        if (scaled_sq >= var9 || &cand) begin
                            delta <= cand;
                            done  <= 1'b1;
                            st    <= SQ_IDLE;
                        end else begin
                            cand <= cand + 1'b1;
                        end
                    end
                    default: st <= SQ_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/pubias_age_checker.sv
module pubias_age_checker
    import pubias_pkg::*;
#(
    parameter int FRAME_BITS = 65536,
    parameter int WORD_W     = 32,
    parameter int CAL_RUNS   = 100,
    localparam int C_W       = cnt_width(FRAME_BITS + WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode_cal,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              busy,
    output logic              frame_err,
    output logic              res_valid,
    output logic              res_used,
    output logic [C_W-1:0]    res_count,
    output logic [C_W-1:0]    res_delta
);
    localparam logic [C_W:0] HALF_C = (C_W + 1)'(FRAME_BITS / 2);

    ctl_state_e     st;
    logic           mode_q;
    logic           take, go;
    logic           frm_done, frm_ok;
    logic [C_W-1:0] frm_ones;
    logic           cal_acc, cal_last, cal_done;
    logic [C_W:0]   lo_sum, hi_lim;
    logic           outside;

    assign in_ready = (st == ST_CAPTURE);
    assign busy     = (st != ST_IDLE);
    assign take     = in_valid && in_ready;
    assign go       = start && (st == ST_IDLE);
    assign cal_acc  = frm_done && frm_ok && (st == ST_CAPTURE) && mode_q;

    pubias_frame_acc #(
        .FRAME_BITS(FRAME_BITS),
        .WORD_W    (WORD_W),
        .C_W       (C_W)
    ) i_frame (
        .clk (clk),
        .rst (rst),
        .clr (go),
        .take(take),
        .data(in_data),
        .sof (in_sof),
        .eof (in_eof),
        .done(frm_done),
        .ok  (frm_ok),
        .ones(frm_ones)
    );

    pubias_cal_stats #(
        .C_W     (C_W),
        .CAL_RUNS(CAL_RUNS)
    ) i_cal (
        .clk  (clk),
        .rst  (rst),
        .clr  (go && mode_cal),
        .acc  (cal_acc),
        .ones (frm_ones),
        .last (cal_last),
        .done (cal_done),
        .delta(res_delta)
    );

    // Band test without subtraction: below if count+delta < half
    always_comb begin
        lo_sum  = {1'b0, frm_ones} + {1'b0, res_delta};
        hi_lim  = HALF_C + {1'b0, res_delta};
        outside = (lo_sum < HALF_C) || ({1'b0, frm_ones} > hi_lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            mode_q    <= 1'b0;
            frame_err <= 1'b0;
            res_valid <= 1'b0;
            res_used  <= 1'b0;
            res_count <= '0;
        end else begin
            frame_err <= 1'b0;
            res_valid <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    mode_q <= mode_cal;
                    st     <= ST_CAPTURE;
                end
                ST_CAPTURE: if (frm_done) begin
                    if (!frm_ok) begin
                        frame_err <= 1'b1;
                    end else begin
                        res_count <= frm_ones;
                        if (mode_q) begin
                            if (cal_last) st <= ST_WAIT;
                        end else begin
                            res_valid <= 1'b1;
                            res_used  <= outside;
                            st        <= ST_IDLE;
                        end
                    end
                end
                ST_WAIT: if (cal_done) begin
                    res_valid <= 1'b1;
                    res_used  <= 1'b0;
                    st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pubias_age_checker_chk.sv
module pubias_age_checker_chk #(
    parameter int FRAME_BITS = 65536,
    parameter int C_W        = 17
) (
    input logic           clk,
    input logic           rst,
    input logic           in_ready,
    input logic           busy,
    input logic           frame_err,
    input logic           res_valid,
    input logic           res_used,
    input logic [C_W-1:0] res_count,
    input logic [C_W-1:0] res_delta
);
    localparam logic [C_W-1:0] HALF_C = C_W'(FRAME_BITS / 2);

    // R6
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> busy);

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> res_valid);

    // R7
    result_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R7
    result_idle_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !busy);

    // R4
    delta_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(res_delta));

    // R5
    err_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> busy);

    // R2
    mid_new_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_count == HALF_C) |-> !res_used);

endmodule

bind pubias_age_checker pubias_age_checker_chk #(
    .FRAME_BITS(FRAME_BITS),
    .C_W       (C_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .busy     (busy),
    .frame_err(frame_err),
    .res_valid(res_valid),
    .res_used (res_used),
    .res_count(res_count),
    .res_delta(res_delta)
);

// File: tb/test_pubias_age_checker.sv
`timescale 1ns/1ps
module test_pubias_age_checker;
    localparam int FB   = 64;
    localparam int WW   = 8;
    localparam int CR   = 4;
    localparam int CW   = $clog2(FB + WW + 1);
    localparam int NW   = FB / WW;

    // Authentication vectors after learning delta = 5 (band 27..37)
    localparam int NV = 8;
    localparam int VEC_ONES [NV] = '{32, 27, 37, 26, 38, 0, 64, 33};
    localparam bit VEC_USED [NV] = '{0,  0,  0,  1,  1,  1, 1,  0};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mode_cal = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [WW-1:0] in_data = '0;
    logic          in_sof = 1'b0;
    logic          in_eof = 1'b0;
    logic          busy, frame_err, res_valid, res_used;
    logic [CW-1:0] res_count, res_delta;

    int n_chk = 0;
    int n_fail = 0;
    int n_res = 0;
    int n_err = 0;
    logic          r_used, r_busy;
    logic [CW-1:0] r_count, r_delta;

    always #2 clk = ~clk;

    pubias_age_checker #(.FRAME_BITS(FB), .WORD_W(WW), .CAL_RUNS(CR)) i_pubias_age_checker (
        .clk(clk), .rst(rst), .start(start), .mode_cal(mode_cal),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .busy(busy), .frame_err(frame_err),
        .res_valid(res_valid), .res_used(res_used), .res_count(res_count),
        .res_delta(res_delta)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (res_valid) begin
                n_res++;
                r_used  = res_used;
                r_count = res_count;
                r_delta = res_delta;
                r_busy  = busy;
            end
            if (frame_err) n_err++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic send_word(input logic [WW-1:0] d, input bit s, input bit e);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    // nwords words, ones packed low first, start flag on word 0
    task automatic send_frame(input int ones, input int nwords);
        for (int w = 0; w < nwords; w++) begin
            int n = ones - WW * w;
            if (n < 0) n = 0;
            if (n > WW) n = WW;
            send_word(WW'((1 << n) - 1), w == 0, w == nwords - 1);
        end
    endtask

    task automatic kick(input bit cal);
        start = 1'b1; mode_cal = cal;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_res(input int prev);
        int t = 0;
        while (n_res == prev && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (n_res == prev) begin
            n_fail++;
            $display("FAIL R7: actual no result expected result");
        end
    endtask

    task automatic auth(input int ones);
        int p = n_res;
        kick(1'b0);
        send_frame(ones, NW);
        wait_res(p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int p, e0;
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9 busy", busy, 0);
        check("R9 in_ready", in_ready, 0);
        check("R9 res_valid", res_valid, 0);
        check("R9 frame_err", frame_err, 0);
        check("R4 delta after reset", res_delta, 0);
        rst = 1'b0;
        @(negedge clk);

        // R6 busy and ready follow start
        kick(1'b0);
        check("R6 busy after start", busy, 1);
        check("R6 ready after start", in_ready, 1);
        p = n_res;
        send_frame(32, NW);
        wait_res(p);
        check("R1 count 32", r_count, 32);
        check("R2 delta 0 mid", r_used, 0);
        check("R7 busy low at result", r_busy, 0);
        check("R6 busy low after", busy, 0);
        auth(31);
        check("R2 delta 0 off by one", r_used, 1);

        // R3 R5 calibration {30,32,34,32} with a short frame inside: delta 5
        p = n_res; e0 = n_err;
        kick(1'b1);
        send_frame(30, NW);
        send_frame(50, NW - 1);
        send_frame(32, NW);
        send_frame(34, NW);
        send_frame(32, NW);
        wait_res(p);
        check("R5 short frame flagged", n_err - e0, 1);
        check("R3 learned delta", r_delta, 5);
        check("R7 cal verdict", r_used, 0);
        check("R7 cal last count", r_count, 32);

        // table of authentication vectors around the band edges
        for (int v = 0; v < NV; v++) begin
            auth(VEC_ONES[v]);
            check("R1 vector count", r_count, VEC_ONES[v]);
            check("R2 vector verdict", r_used, VEC_USED[v]);
        end
        check("R4 delta kept", res_delta, 5);

        // R8 stray start during authentication
        p = n_res;
        kick(1'b0);
        for (int w = 0; w < 4; w++) send_word(8'hFF, w == 0, 1'b0);
        kick(1'b1);
        for (int w = 0; w < 4; w++) send_word(8'h00, 1'b0, w == 3);
        wait_res(p);
        check("R8 ran as auth count", r_count, 32);
        check("R8 ran as auth verdict", r_used, 0);
        check("R8 delta untouched", res_delta, 5);

        // R10 start flag restarts a partial frame
        p = n_res;
        kick(1'b0);
        for (int w = 0; w < 3; w++) send_word(8'hFF, w == 0, 1'b0);
        send_frame(40, NW);
        wait_res(p);
        check("R10 restarted count", r_count, 40);
        check("R10 verdict", r_used, 1);

        // R5 long frame during constant calibration: delta 0
        p = n_res; e0 = n_err;
        kick(1'b1);
        send_frame(20, NW);
        send_frame(60, NW + 1);
        for (int k = 0; k < 3; k++) send_frame(20, NW);
        wait_res(p);
        check("R5 long frame flagged", n_err - e0, 1);
        check("R3 zero spread delta", r_delta, 0);
        auth(33);
        check("R2 zero band above", r_used, 1);

        // R9 reset clears learned delta
        p = n_res;
        kick(1'b1);
        send_frame(10, NW);
        send_frame(50, NW);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 delta cleared", res_delta, 0);
        check("R9 busy cleared", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 no result", n_res - p, 0);

        finish_run();
    end
endmodule